// File: doc/BRIEF.md
# Multiplexed External Memory Bus Front End

This block connects the internal memory requests of a 16-bit controller with a 20-bit address space to an external bus. The bus uses few pins because address and data share them. A requester asks for a code fetch, a data read or a data write. It supplies a word address, write data and byte enables. The block then runs one or two four-phase bus cycles.

The address goes out in three parts:
- Bits 1 to 3 go on dedicated pins.
- Bits 4 to 11 go on the low shared port, which later carries data bits 0 to 7.
- Bits 12 to 19 go on the high shared port. In 16-bit mode this port later carries data bits 8 to 15.

An external latch captures the address on the falling edge of the address latch strobe. After that, a strobe chosen by the request kind moves the data. The strobe is the program store enable, the read strobe or a write strobe.

The bus width comes from a strap pin. The block samples the strap once when reset is released. In 8-bit mode:
- The pin shared by address bit 0 and the high-byte write strobe carries address bit 0.
- A word access becomes two byte cycles.
- A count input sets how many of the upper address lines appear on the high port. The block leaves the remaining high-port pins undriven.

Top module: `extbus_if`

## Requirements
- R1: At the first clock edge after `rst_n` rises, `width_strap` is sampled: 0 selects the 8-bit bus and 1 selects the 16-bit bus. `req_ready` stays low until that edge. Later changes of the strap have no effect until the next reset.
- R2: `req_ready` is high only while the interface is idle. A request (`req_valid` high) is taken only at an edge where `req_ready` is high. Requests made during an access do not change that access.
- R3: Each bus cycle has four phases of one clock each:
  - T1: `ale` is high and the shared ports drive the address.
  - T2: `ale` is low and the address is held.
  - T3: the strobe is low.
  - T4: the strobe is released.
- R4: `done` is high during T4 of the last bus cycle. `req_ready` returns high in the following clock. The first T1 follows the accepting edge directly.
- R5: `addr_lo` always shows address bits 3:1. In T1 and T2, `p0_out` carries address bits 11:4 and `p2_out` carries address bits 19:12.
- R6: Kind encoding: 00 is a fetch and asserts `psen_n`; 01 is a read and asserts `rd_n`; 1x is a write. At most one of the fetch, read and write strobe groups is active, and none while `ale` is high.
- R7: In 16-bit mode a write asserts `wrl_n` if byte enable bit 0 is set. It asserts `a0_wrh` (active low) if bit 1 is set. The write data is driven on `{p2_out, p0_out}` in T3 and T4.
- R8: In 8-bit mode, `a0_wrh` is address bit 0. Each enabled byte gets its own bus cycle, low byte first, with `a0_wrh` = 0 for byte 0 and 1 for byte 1. Data uses `p0` only, and `wrl_n` strobes every byte write.
- R9: In 8-bit mode, `p2_oe` during T1 and T2 enables only the lowest N pins, where N = `upper_lines` capped at 8. Outside T1 and T2 the high port is not driven.
- R10: During T3 and T4 of a fetch or read, both shared ports are undriven. Data is captured at the edge that ends T3. In 16-bit mode the whole word comes from `{p2_in, p0_in}`. In 8-bit mode bytes that are not enabled read as 0. `rdata` is valid while `done` is high.
- R11: A byte enable value of 00 is treated as 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| width_strap | input | 1 | Bus width strap, sampled after reset |
| upper_lines | input | 4 | Number of upper address lines on the high port in 8-bit mode |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 fetch, 01 read, 1x write |
| req_addr | input | 20 | Byte address; bit 0 is ignored |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables |
| req_ready | output | 1 | Interface idle, request can be taken |
| done | output | 1 | Final phase of the access |
| rdata | output | 16 | Read data |
| addr_lo | output | 3 | Address bits 3:1 |
| a0_wrh | output | 1 | Address bit 0 (8-bit) or high write strobe, active low (16-bit) |
| p0_out | output | 8 | Low shared port output |
| p0_oe | output | 1 | Low shared port drive enable |
| p0_in | input | 8 | Low shared port input |
| p2_out | output | 8 | High shared port output |
| p2_oe | output | 8 | High shared port per-pin drive enable |
| p2_in | input | 8 | High shared port input |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wrl_n | output | 1 | Low byte write strobe, active low |

## Verification
Some properties are checked by assertions on every cycle:
- The strobe groups are mutually exclusive, and no strobe is active while `ale` is high.
- The shared ports release during read strobes.
- In 8-bit mode, no high-port pin beyond the programmed count is ever driven.
- The latched width does not move after its sampling edge.
- `done` is followed by idle.
- A taken request starts at T1.

Other behaviour appears only in the bench scenarios:
- the address split across pins;
- the byte lane and strobe chosen for each enable pattern;
- the low-first ordering of split word accesses;
- the clearing of bytes that were not enabled;
- the strap being ignored after reset.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_T4   = 3'd4
  } phase_t;

  localparam logic [1:0] KIND_FETCH = 2'b00;
  localparam logic [1:0] KIND_READ  = 2'b01;

  function automatic logic kind_is_write(input logic [1:0] k);
    return k[1];
  endfunction

  // zero enables mean a full word
  function automatic logic [1:0] norm_be(input logic [1:0] be);
    return (be == 2'b00) ? 2'b11 : be;
  endfunction

  // a word on a byte-wide bus needs two cycles
  function automatic logic needs_split(input logic wide, input logic [1:0] be);
    return !wide && (be == 2'b11);
  endfunction

  // pin enable mask for the upper address lines in 8-bit mode
  function automatic logic [7:0] upper_mask(input logic [3:0] n);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = (i < int'(n));
    return m;
  endfunction

endpackage

// File: rtl/extbus_seq.sv
module extbus_seq
  import extbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   split,
  output phase_t phase,
  output logic   second,
  output logic   done
);

  logic last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      second <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase  <= PH_T1;
          second <= 1'b0;
        end
        PH_T1: phase <= PH_T2;
        PH_T2: phase <= PH_T3;
        PH_T3: phase <= PH_T4;
        PH_T4: begin
          if (split && !second) begin
            phase  <= PH_T1;
            second <= 1'b1;
          end else begin
            phase  <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign last = !split || second;
  assign done = (phase == PH_T4) && last;

  // R4
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (phase == PH_IDLE));

  // R3
  start_to_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && phase == PH_IDLE) |=> (phase == PH_T1));

endmodule

// File: rtl/extbus_lanes.sv
module extbus_lanes
  import extbus_pkg::*;
#(
  parameter int AW   = 20,
  parameter int BW   = 8,
  parameter int LOWA = 4,
  localparam int DW  = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_t        phase,
  input  logic [1:0]    kind,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    be,
  input  logic          wide,
  input  logic          idx,
  input  logic [3:0]    n_upper,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wrl_n,
  output logic          a0_wrh,
  output logic [LOWA-2:0] addr_lo,
  output logic          p0_oe,
  output logic [BW-1:0] p0_out,
  output logic [BW-1:0] p2_oe,
  output logic [BW-1:0] p2_out
);

  logic wr, addr_ph, strobe_ph, data_ph;
  logic [BW-1:0] mask;

  assign wr        = kind_is_write(kind);
  assign addr_ph   = (phase == PH_T1) || (phase == PH_T2);
  assign strobe_ph = (phase == PH_T3);
  assign data_ph   = (phase == PH_T3) || (phase == PH_T4);
  assign mask      = upper_mask(n_upper);

  assign ale     = (phase == PH_T1);
  assign psen_n  = !(strobe_ph && kind == KIND_FETCH);
  assign rd_n    = !(strobe_ph && kind == KIND_READ);
  assign wrl_n   = !(strobe_ph && wr && (wide ? be[0] : 1'b1));
  assign a0_wrh  = wide ? !(strobe_ph && wr && be[1]) : idx;
  assign addr_lo = addr[LOWA-1:1];

  assign p0_oe  = addr_ph || (data_ph && wr);
  assign p0_out = addr_ph ? addr[LOWA+BW-1:LOWA]
                : ((wide || !idx) ? wdata[BW-1:0] : wdata[DW-1:BW]);

  assign p2_oe  = wide ? {BW{p0_oe}} : (addr_ph ? mask : '0);
  assign p2_out = addr_ph ? addr[AW-1:LOWA+BW] : wdata[DW-1:BW];

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!psen_n, !rd_n, (!wrl_n || (wide && !a0_wrh))}));

  // R6
  ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wrl_n));

  // R10
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !psen_n) |-> (!p0_oe && p2_oe == '0));

  // R9
  upper_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> ((p2_oe & ~mask) == '0));

endmodule

// File: rtl/extbus_if.sv
module extbus_if
  import extbus_pkg::*;
#(
  parameter int AW   = 20,
  parameter int BW   = 8,
  parameter int LOWA = 4,
  localparam int DW  = 2 * BW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            width_strap,
  input  logic [3:0]      upper_lines,
  input  logic            req_valid,
  input  logic [1:0]      req_kind,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [1:0]      req_be,
  output logic            req_ready,
  output logic            done,
  output logic [DW-1:0]   rdata,
  output logic [LOWA-2:0] addr_lo,
  output logic            a0_wrh,
  output logic [BW-1:0]   p0_out,
  output logic            p0_oe,
  input  logic [BW-1:0]   p0_in,
  output logic [BW-1:0]   p2_out,
  output logic [BW-1:0]   p2_oe,
  input  logic [BW-1:0]   p2_in,
  output logic            ale,
  output logic            psen_n,
  output logic            rd_n,
  output logic            wrl_n
);

  logic          armed, wide;
  logic [1:0]    q_kind, q_be;
  logic [AW-1:0] q_addr;
  logic [DW-1:0] q_wdata;
  logic [3:0]    q_upper;
  phase_t        phase;
  logic          second, split, start, idx;

  // width strap sampled at the first edge after reset release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b1;
      wide  <= 1'b0;
    end else if (armed) begin
      armed <= 1'b0;
      wide  <= width_strap;
    end
  end

  assign req_ready = !armed && (phase == PH_IDLE);
  assign start     = req_valid && req_ready;
  assign split     = needs_split(wide, q_be);
  assign idx       = split ? second : (q_be == 2'b10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_kind  <= KIND_FETCH;
      q_be    <= 2'b11;
      q_addr  <= '0;
      q_wdata <= '0;
      q_upper <= '0;
      rdata   <= '0;
    end else if (start) begin
      q_kind  <= req_kind;
      q_be    <= norm_be(req_be);
      q_addr  <= req_addr;
      q_wdata <= req_wdata;
      q_upper <= upper_lines;
      rdata   <= '0;
    end else if (phase == PH_T3 && !kind_is_write(q_kind)) begin
      if (wide)     rdata <= {p2_in, p0_in};
      else if (idx) rdata[DW-1:BW] <= p0_in;
      else          rdata[BW-1:0]  <= p0_in;
    end
  end

  extbus_seq i_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .split  (split),
    .phase  (phase),
    .second (second),
    .done   (done)
  );

  extbus_lanes #(.AW(AW), .BW(BW), .LOWA(LOWA)) i_lanes (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase   (phase),
    .kind    (q_kind),
    .addr    (q_addr),
    .wdata   (q_wdata),
    .be      (q_be),
    .wide    (wide),
    .idx     (idx),
    .n_upper (q_upper),
    .ale     (ale),
    .psen_n  (psen_n),
    .rd_n    (rd_n),
    .wrl_n   (wrl_n),
    .a0_wrh  (a0_wrh),
    .addr_lo (addr_lo),
    .p0_oe   (p0_oe),
    .p0_out  (p0_out),
    .p2_oe   (p2_oe),
    .p2_out  (p2_out)
  );

  // R1
  width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> $stable(wide));

  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> !req_ready);

endmodule

// File: tb/test_extbus_if.sv
module test_extbus_if;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        width_strap = 1'b1;
  logic [3:0]  upper_lines = 4'd8;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = 2'b11;
  logic [7:0]  p0_in = '0, p2_in = '0;
  logic        req_ready, done, a0_wrh, p0_oe, ale, psen_n, rd_n, wrl_n;
  logic [15:0] rdata;
  logic [2:0]  addr_lo;
  logic [7:0]  p0_out, p2_out, p2_oe;

  int checks = 0, fails = 0;
  bit m16 = 1'b1;

  always #5 clk = ~clk;

  extbus_if i_extbus_if (
    .clk(clk), .rst_n(rst_n), .width_strap(width_strap), .upper_lines(upper_lines),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready), .done(done),
    .rdata(rdata), .addr_lo(addr_lo), .a0_wrh(a0_wrh), .p0_out(p0_out),
    .p0_oe(p0_oe), .p0_in(p0_in), .p2_out(p2_out), .p2_oe(p2_oe), .p2_in(p2_in),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wrl_n(wrl_n)
  );

  function automatic logic [7:0] memb(input logic [19:0] a);
    return 8'((int'(a) * 37 + 11) & 255);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] pins(input logic a0_care);
    return {ale, psen_n, rd_n, wrl_n, (a0_care ? a0_wrh : 1'b0), addr_lo, p0_oe,
            p0_out & {8{p0_oe}}, p2_oe, p2_out & p2_oe, done, req_ready};
  endfunction

  task automatic chk_idle(input string tag);
    chk(tag, pins(1'b0), {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, addr_lo, 1'b0, 8'h00,
                          8'h00, 8'h00, 1'b0, 1'b1});
  endtask

  // behavioural reference: list of byte cycles, four phases each
  task automatic access(input logic [1:0] kind, input logic [19:0] a,
                        input logic [15:0] wd, input logic [1:0] be, input bit noisy);
    logic [1:0] bex;
    int lanes[$];
    logic [15:0] exp_rd;
    logic [7:0] mk;
    bit wr;
    bex = (be == 2'b00) ? 2'b11 : be;
    wr = kind[1];
    mk = 8'h00;
    for (int i = 0; i < 8; i++) if (i < int'(upper_lines)) mk[i] = 1'b1;
    if (m16) lanes.push_back(2);
    else for (int i = 0; i < 2; i++) if (bex[i]) lanes.push_back(i);
    exp_rd = m16 ? {memb({a[19:1], 1'b1}), memb({a[19:1], 1'b0})} : 16'h0000;
    if (!m16) begin
      if (bex[0]) exp_rd[7:0]  = memb({a[19:1], 1'b0});
      if (bex[1]) exp_rd[15:8] = memb({a[19:1], 1'b1});
    end
    req_valid = 1'b1; req_kind = kind; req_addr = a; req_wdata = wd; req_be = be;
    @(negedge clk);
    for (int j = 0; j < lanes.size(); j++) begin
      for (int t = 1; t <= 4; t++) begin
        logic s, lastc, e_oe0, e_a0, e_wrl;
        logic [7:0] e_p0, e_oe2, e_p2;
        s = (t == 3);
        lastc = (j == lanes.size() - 1);
        if (noisy && t < 3) begin
          req_valid = 1'b1; req_addr = ~a; req_kind = ~kind; req_wdata = ~wd;
        end else req_valid = 1'b0;
        if (s) begin
          if (m16) begin p0_in = memb({a[19:1], 1'b0}); p2_in = memb({a[19:1], 1'b1}); end
          else begin p0_in = memb({a[19:1], lanes[j][0]}); p2_in = 8'hA5; end
        end
        e_oe0 = (t <= 2) || wr;
        e_p0  = (t <= 2) ? a[11:4] : ((m16 || lanes[j] == 0) ? wd[7:0] : wd[15:8]);
        e_oe2 = m16 ? {8{e_oe0}} : ((t <= 2) ? mk : 8'h00);
        e_p2  = (t <= 2) ? a[19:12] : wd[15:8];
        e_a0  = m16 ? !(s && wr && bex[1]) : lanes[j][0];
        e_wrl = !(s && wr && (m16 ? bex[0] : 1'b1));
        chk("R3 R4 R5 R6 R7 R8 R9 R10 bus pins", pins(1'b1),
            {(t == 1), !(s && kind == 2'b00), !(s && kind == 2'b01), e_wrl, e_a0,
             a[3:1], e_oe0, e_p0 & {8{e_oe0}}, e_oe2, e_p2 & e_oe2,
             (t == 4 && lastc), 1'b0});
        if (t == 4 && lastc && !wr) chk("R10 read data", 64'(rdata), 64'(exp_rd));
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    chk_idle("R2 R4 idle after access");
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0; width_strap = strap;
    repeat (3) @(negedge clk);
    chk("R2 reset state", pins(1'b0), {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, addr_lo, 1'b0,
                                        8'h00, 8'h00, 8'h00, 1'b0, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 ready after strap sampling");
    m16 = strap;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // 16-bit bus
    do_reset(1'b1);
    access(2'b00, 20'hABCDE, 16'h0000, 2'b11, 0);   // R6 fetch
    access(2'b01, 20'h12344, 16'h0000, 2'b11, 0);   // R10 read word
    access(2'b10, 20'h5A5A0, 16'hBEEF, 2'b11, 0);   // R7 both strobes
    access(2'b10, 20'h00010, 16'h1234, 2'b01, 0);   // R7 low only
    access(2'b11, 20'hFFFFE, 16'hCAFE, 2'b10, 0);   // R7 high only
    access(2'b01, 20'h7777A, 16'h0000, 2'b00, 0);   // R11
    width_strap = 1'b0;                              // R1 ignored after reset
    @(negedge clk);
    access(2'b10, 20'h0F0F2, 16'h8421, 2'b11, 1);   // R1 R2 still wide, noisy
    // 8-bit bus
    do_reset(1'b0);
    upper_lines = 4'd8;
    access(2'b00, 20'h3C3C6, 16'h0000, 2'b11, 0);   // R8 split low first
    access(2'b01, 20'h9876A, 16'h0000, 2'b10, 1);   // R8 R10 high byte only
    access(2'b10, 20'h11112, 16'hA55A, 2'b01, 0);   // R8 low byte write
    upper_lines = 4'd3;
    access(2'b10, 20'hFEDCC, 16'h6789, 2'b11, 0);   // R9 three lines
    upper_lines = 4'd0;
    access(2'b01, 20'h24680, 16'h0000, 2'b01, 0);   // R9 no lines
    upper_lines = 4'd12;
    access(2'b10, 20'h13578, 16'h3141, 2'b00, 0);   // R9 cap, R11
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule